// File: doc/BRIEF.md
# DMA Channel Reset Sequencer

This block drives a DMA channel into a clean reset state through a plain command and status interface. A start pulse launches the sequence. The sequencer first reads the channel status. If the channel is still running or parked, it sends a suspend command and waits for the channel to leave those two states. It then flushes the channel's write-one-to-clear error register by reading it and writing the same value back. Finally it sends a reset command and waits for the channel's self-clearing reset-pending bit to drop.

Each of the two waits is bounded by a count of millisecond ticks taken from an input strobe, so a test can shorten a millisecond to a few clock cycles. At the end, the sequencer gives a one-cycle success pulse, or a one-cycle failure pulse with a code that names the wait that ran out. The channel appears only as its status code, its reset-pending bit, its error register value and the command strobes. All pins are plain control and status pins with no handshake; no data moves through the block.

Top module: `dma_chan_rst_seq`

## Requirements
- R1: When a start pulse is accepted, the status code is examined on the next clock. If it equals the running code (default 0) or the parked code (default 1), `cmd_suspend_o` pulses for exactly one cycle. Any other code skips the suspend and goes straight to the error flush.
- R2: After a suspend, the status is sampled only on clocks where `ms_tick_i` is high. The sequence moves on at the first such tick where the status is neither running nor parked.
- R3: If the status is still running or parked on the TICK_LIMIT-th tick after the suspend (default 20), `err_o` pulses with `err_code_o` = 2'b01. No reset command is issued in that case.
- R4: The error flush samples `err_rd_data_i` for one cycle. On the following cycle it pulses `err_wr_o` for one cycle, with `err_wr_data_o` equal to the sampled value. Writing that value back leaves a write-one-to-clear register at zero.
- R5: The cycle after the flush write, `cmd_reset_o` pulses for one cycle. After that, `rst_pending_i` is sampled only on tick clocks, and `done_o` pulses on the clock after the first tick that finds it low.
- R6: If `rst_pending_i` is still high on the TICK_LIMIT-th tick after the reset command, `err_o` pulses with `err_code_o` = 2'b10.
- R7: `done_o`, `err_o`, `err_wr_o`, `cmd_suspend_o` and `cmd_reset_o` are one-cycle pulses, and no two of them are ever high together. `err_code_o` is 2'b00 whenever `err_o` is low.
- R8: `busy_o` is high from the clock after an accepted start until the clock after the `done_o` or `err_o` pulse. A start pulse that arrives while `busy_o` is high is ignored.
- R9: While reset is asserted, and right after it is released, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a reset sequence (taken only when idle) |
| ms_tick_i | input | 1 | One-cycle strobe marking each millisecond |
| chan_status_i | input | ST_W | Channel status code |
| rst_pending_i | input | 1 | Channel's self-clearing reset-in-progress bit |
| err_rd_data_i | input | ERR_W | Current value of the channel error register |
| cmd_suspend_o | output | 1 | Suspend command strobe |
| cmd_reset_o | output | 1 | Reset command strobe |
| err_wr_o | output | 1 | Error register write strobe |
| err_wr_data_o | output | ERR_W | Value written to the error register |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished successfully |
| err_o | output | 1 | Sequence aborted on a timeout |
| err_code_o | output | 2 | 01 = suspend wait expired, 10 = reset wait expired |

## Verification
Every output is decoded from registered sequencer state, so a wrong state shows at the ports in the very next cycle. A skipped, repeated or misplaced command strobe, a flush value that does not match, or a busy flag that drops early all appear there. A wrong tick count does not show until the wait ends. Then the success or failure pulse arrives on the wrong tick, or carries the wrong code. Tests that set the channel to clear on exactly the last allowed tick, and on the tick after it, expose an off-by-one count within one tick.

// File: rtl/dma_rst_pkg.sv
package dma_rst_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_CHECK,
    SQ_SUSP_CMD,
    SQ_SUSP_WAIT,
    SQ_ERR_RD,
    SQ_ERR_WR,
    SQ_RST_CMD,
    SQ_RST_WAIT,
    SQ_OK,
    SQ_FAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    FAIL_NONE = 2'b00,
    FAIL_SUSP = 2'b01,
    FAIL_RST  = 2'b10
  } fail_code_e;

endpackage

// File: rtl/rst_tick_timer.sv
module rst_tick_timer #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (tick_i && cnt_q < TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == TOP);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rst_err_flush.sv
module rst_err_flush #(
  parameter int ERR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             wr_i,
  input  logic [ERR_W-1:0] rd_data_i,
  output logic             wr_o,
  output logic [ERR_W-1:0] wr_data_o
);
  logic [ERR_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (cap_i) snap_q <= rd_data_i;
  end

  assign wr_o      = wr_i;
  assign wr_data_o = wr_i ? snap_q : '0;

  // R4
  wb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && $past(cap_i)) |-> (wr_data_o == $past(rd_data_i)));

  // R4
  wr_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> $past(cap_i));

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import dma_rst_pkg::*;
#(
  parameter int              ST_W      = 3,
  parameter logic [ST_W-1:0] ST_RUN    = '0,
  parameter logic [ST_W-1:0] ST_PARKED = ST_W'(1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            tick_i,
  input  logic [ST_W-1:0] status_i,
  input  logic            rst_pending_i,
  input  logic            tmr_last_i,
  output logic            tmr_clr_o,
  output logic            cap_o,
  output logic            wr_o,
  output logic            cmd_suspend_o,
  output logic            cmd_reset_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [1:0]      err_code_o
);
  seq_state_e st_q, st_d;
  fail_code_e code_q, code_d;
  logic       chan_live;

  assign chan_live = (status_i == ST_RUN) || (status_i == ST_PARKED);

  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    unique case (st_q)
      SQ_IDLE:      if (start_i) begin
                      st_d   = SQ_CHECK;
                      code_d = FAIL_NONE;
                    end
      SQ_CHECK:     st_d = chan_live ? SQ_SUSP_CMD : SQ_ERR_RD;
      SQ_SUSP_CMD:  st_d = SQ_SUSP_WAIT;
      SQ_SUSP_WAIT: if (tick_i) begin
                      if (!chan_live)      st_d = SQ_ERR_RD;
                      else if (tmr_last_i) begin
                        st_d   = SQ_FAIL;
                        code_d = FAIL_SUSP;
                      end
                    end
      SQ_ERR_RD:    st_d = SQ_ERR_WR;
      SQ_ERR_WR:    st_d = SQ_RST_CMD;
      SQ_RST_CMD:   st_d = SQ_RST_WAIT;
      SQ_RST_WAIT:  if (tick_i) begin
                      if (!rst_pending_i)  st_d = SQ_OK;
                      else if (tmr_last_i) begin
                        st_d   = SQ_FAIL;
                        code_d = FAIL_RST;
                      end
                    end
      SQ_OK:        st_d = SQ_IDLE;
      SQ_FAIL:      st_d = SQ_IDLE;
      default:      st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      code_q <= FAIL_NONE;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
    end
  end

  assign tmr_clr_o     = (st_q == SQ_SUSP_CMD) || (st_q == SQ_RST_CMD);
  assign cap_o         = (st_q == SQ_ERR_RD);
  assign wr_o          = (st_q == SQ_ERR_WR);
  assign cmd_suspend_o = (st_q == SQ_SUSP_CMD);
  assign cmd_reset_o   = (st_q == SQ_RST_CMD);
  assign busy_o        = (st_q != SQ_IDLE);
  assign done_o        = (st_q == SQ_OK);
  assign err_o         = (st_q == SQ_FAIL);
  assign err_code_o    = (st_q == SQ_FAIL) ? code_q : FAIL_NONE;

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o, wr_o, cmd_suspend_o, cmd_reset_o}));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |=> !(done_o || err_o));

  // R5
  rst_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset_o |-> $past(wr_o));

  // R3
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_code_o != 2'b00));

  // R8
  idle_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |=> !busy_o);

endmodule

// File: rtl/dma_chan_rst_seq.sv
module dma_chan_rst_seq #(
  parameter int              ST_W       = 3,
  parameter logic [ST_W-1:0] ST_RUN     = '0,
  parameter logic [ST_W-1:0] ST_PARKED  = ST_W'(1),
  parameter int              ERR_W      = 32,
  parameter int              TICK_LIMIT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ms_tick_i,
  input  logic [ST_W-1:0]  chan_status_i,
  input  logic             rst_pending_i,
  input  logic [ERR_W-1:0] err_rd_data_i,
  output logic             cmd_suspend_o,
  output logic             cmd_reset_o,
  output logic             err_wr_o,
  output logic [ERR_W-1:0] err_wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [1:0]       err_code_o
);
  logic tmr_clr, tmr_last, cap, wr;

  rst_seq_fsm #(
    .ST_W(ST_W), .ST_RUN(ST_RUN), .ST_PARKED(ST_PARKED)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(ms_tick_i),
    .status_i(chan_status_i), .rst_pending_i(rst_pending_i),
    .tmr_last_i(tmr_last), .tmr_clr_o(tmr_clr), .cap_o(cap), .wr_o(wr),
    .cmd_suspend_o(cmd_suspend_o), .cmd_reset_o(cmd_reset_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  rst_tick_timer #(.LIMIT(TICK_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .tick_i(ms_tick_i),
    .last_o(tmr_last)
  );

  rst_err_flush #(.ERR_W(ERR_W)) u_flush (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .wr_i(wr),
    .rd_data_i(err_rd_data_i), .wr_o(err_wr_o), .wr_data_o(err_wr_data_o)
  );

endmodule

// File: tb/tb_dma_chan_rst_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_rst_seq;
  localparam int LIM = 20;
  localparam int TDIV = 5;

  logic clk = 0, rst_n = 0, start_i = 0, ms_tick_i = 0, rst_pending_i = 0;
  logic [2:0]  chan_status_i = 3'd2;
  logic [31:0] err_rd_data_i;
  logic cmd_suspend_o, cmd_reset_o, err_wr_o, busy_o, done_o, err_o;
  logic [31:0] err_wr_data_o;
  logic [1:0]  err_code_o;

  always #4 clk = ~clk;

  dma_chan_rst_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ms_tick_i(ms_tick_i),
    .chan_status_i(chan_status_i), .rst_pending_i(rst_pending_i),
    .err_rd_data_i(err_rd_data_i), .cmd_suspend_o(cmd_suspend_o),
    .cmd_reset_o(cmd_reset_o), .err_wr_o(err_wr_o), .err_wr_data_o(err_wr_data_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // channel model: bench-side stimulus
  logic [31:0] err_reg = 0;
  int tdiv = 0, susp_after = 1, rst_after = 1, sc = 0, rc = 0;
  bit susp_armed = 0;
  assign err_rd_data_i = err_reg;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TDIV;
    ms_tick_i <= (tdiv == 0);
    if (tdiv == 0 && susp_armed) begin
      sc++;
      if (sc == susp_after) begin chan_status_i <= 3'd2; susp_armed = 0; end
    end
    if (tdiv == 0 && rst_pending_i) begin
      rc++;
      if (rc == rst_after) rst_pending_i <= 0;
    end
    if (cmd_suspend_o) begin susp_armed = 1; sc = 0; end
    if (cmd_reset_o) begin rst_pending_i <= 1; rc = 0; end
    if (err_wr_o) err_reg <= err_reg & ~err_wr_data_o;
  end

  // behavioural reference: phase numbers, tick counter, captured word
  int ph = 0, mcnt = 0, mcode = 0;
  logic [31:0] mcap = 0;
  always @(posedge clk) begin
    if (!rst_n) begin ph = 0; mcnt = 0; mcode = 0; end
    else begin
      case (ph)
        0: if (start_i) begin ph = 1; mcode = 0; end
        1: ph = (chan_status_i <= 3'd1) ? 2 : 4;
        2: begin ph = 3; mcnt = 0; end
        3: if (ms_tick_i) begin
             mcnt++;
             if (chan_status_i > 3'd1) ph = 4;
             else if (mcnt >= LIM) begin ph = 9; mcode = 1; end
           end
        4: begin mcap = err_rd_data_i; ph = 5; end
        5: ph = 6;
        6: begin ph = 7; mcnt = 0; end
        7: if (ms_tick_i) begin
             mcnt++;
             if (!rst_pending_i) ph = 8;
             else if (mcnt >= LIM) begin ph = 9; mcode = 2; end
           end
        default: ph = 0;
      endcase
    end
  end

  // cycle compare
  int n_susp = 0, n_rst = 0, n_done = 0, n_err = 0, last_code = 0;
  always @(negedge clk) if (rst_n) begin
    chk(cmd_suspend_o == (ph == 2), "R1", cmd_suspend_o, ph == 2);
    chk(cmd_reset_o == (ph == 6), "R5", cmd_reset_o, ph == 6);
    chk(err_wr_o == (ph == 5), "R4", err_wr_o, ph == 5);
    if (ph == 5) chk(err_wr_data_o == mcap, "R4", err_wr_data_o, mcap);
    chk(done_o == (ph == 8), "R2", done_o, ph == 8);
    chk(err_o == (ph == 9), "R6", err_o, ph == 9);
    chk(int'(err_code_o) == ((ph == 9) ? mcode : 0), "R7", err_code_o, (ph == 9) ? mcode : 0);
    chk(busy_o == (ph != 0), "R8", busy_o, ph != 0);
    if (cmd_suspend_o) n_susp++;
    if (cmd_reset_o) n_rst++;
    if (done_o) n_done++;
    if (err_o) begin n_err++; last_code = err_code_o; end
  end

  task automatic run(input logic [2:0] st, input int sa, input int ra, input logic [31:0] ev,
                     input bit dbl, input int exp_susp, input int exp_rst,
                     input int exp_done, input int exp_code, input string req);
    @(negedge clk);
    chan_status_i = st; susp_after = sa; rst_after = ra; err_reg = ev;
    n_susp = 0; n_rst = 0; n_done = 0; n_err = 0; last_code = 0;
    start_i = 1;
    @(negedge clk); start_i = 0;
    if (dbl) begin
      repeat (3) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
    end
    for (int i = 0; i < 1000 && n_done == 0 && n_err == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_susp == exp_susp, req, n_susp, exp_susp);
    chk(n_rst == exp_rst, req, n_rst, exp_rst);
    chk(n_done == exp_done, req, n_done, exp_done);
    chk(last_code == exp_code, req, last_code, exp_code);
    chk(busy_o == 0, "R8", busy_o, 0);
    if (exp_done == 1) chk(err_reg == 0, "R4", err_reg, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({cmd_suspend_o, cmd_reset_o, err_wr_o, busy_o, done_o, err_o, err_code_o} == 0,
        "R9", {cmd_suspend_o, cmd_reset_o, err_wr_o, busy_o, done_o, err_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({busy_o, done_o, err_o} == 0, "R9", {busy_o, done_o, err_o}, 0);
    // R1: status 2 skips suspend
    run(3'd2, 1, 2, 32'hA5A5_0001, 0, 0, 1, 1, 0, "R1");
    // R2: running, suspends after 3 ticks
    run(3'd0, 3, 4, 32'h0000_F00D, 0, 1, 1, 1, 0, "R2");
    // R2 boundary: parked, clears exactly at last tick
    run(3'd1, LIM, 1, 32'h8000_0000, 0, 1, 1, 1, 0, "R2");
    // R3: clears one tick too late
    run(3'd1, LIM + 1, 1, 32'h1234_5678, 0, 1, 0, 0, 1, "R3");
    chan_status_i = 3'd2;
    repeat (200) @(negedge clk);
    // R5 boundary: pending drops exactly at last tick
    run(3'd3, 1, LIM, 32'hFFFF_FFFF, 0, 0, 1, 1, 0, "R5");
    // R6: pending never drops in time
    run(3'd4, 1, LIM + 1, 32'h0F0F_0F0F, 0, 0, 1, 0, 2, "R6");
    repeat (50) @(negedge clk);
    // R8: second start while busy is ignored
    run(3'd0, 2, 2, 32'h0000_0003, 1, 1, 1, 1, 0, "R8");
    // R4: zero error word
    run(3'd5, 1, 1, 32'h0, 0, 0, 1, 1, 0, "R4");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule